// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out the column address for every beat of a memory burst. A controller pulses the start strobe together with the first column, a burst length code and an ordering bit. From the next clock on, the block presents one column address per cycle, with a beat-valid flag, until the burst is complete. Fixed bursts of 1, 2, 4 or 8 beats keep the upper column bits and step only the low bits. The low bits follow either a wrapping count or an XOR pattern. A full-page burst steps through all 256 columns, wraps at the top and keeps running until it is stopped.

A new start is accepted on any cycle and replaces the running burst straight away. A stop strobe ends the running burst. The last-beat flag marks the final beat of a fixed burst so that the controller can schedule its next command.

The control is a three-state machine. IDLE means no burst is running. FIXED means a burst of 1 to 8 beats is running. PAGE means an open-ended full-page burst is running. The transitions are:
- IDLE goes to FIXED or PAGE on a start, depending on the length code.
- FIXED goes to IDLE after its final beat or on a stop.
- PAGE goes to IDLE only on a stop.
- From any state, a start goes to FIXED or PAGE, depending on the new length code, and the beat count restarts from zero.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after reset is released with no start, beat_vld_o and last_o are 0.
- R2: When start_i is sampled high at a clock edge, the outputs in the following cycle show beat 0: beat_vld_o=1 and col_o equal to start_col_i.
- R3: Length code blen_i: 3'b000=1 beat, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=full page. The reserved codes 3'b100 to 3'b110 give a single beat.
- R4: Sequential order (ilv_i=0). For a fixed burst of L beats, beat n has its low log2(L) bits equal to (start + n) mod L, and the upper bits equal to the start column's upper bits.
- R5: Interleaved order (ilv_i=1). For a fixed burst of L beats, beat n has its low log2(L) bits equal to the start column's low bits XOR n, and the upper bits unchanged.
- R6: A full-page burst ignores ilv_i. Its column increases by one per cycle modulo 256, and it runs until a stop or a new start.
- R7: last_o is 1 only on the final beat of a fixed burst and never during a full-page burst. In the cycle after a final beat with no new start, beat_vld_o is 0.
- R8: stop_i sampled high during a burst, with start_i low, makes beat_vld_o 0 in the next cycle. stop_i while idle has no effect.
- R9: A start during a running burst makes the next cycle show beat 0 of the new burst, with the new column, length and order.
- R10: When start_i and stop_i are high in the same cycle, the start wins and the new burst begins.
- R11: Column, length and order are sampled only with the start strobe. Changes on those inputs during a burst do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | 8 | First column of the burst |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | End the running burst |
| col_o | output | 8 | Column address of the current beat |
| beat_vld_o | output | 1 | A burst beat is present this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
Sequential bursts start at unaligned columns near the top of a block, such as 0x3E with four beats. This separates a wrap inside the block from a carry into the upper bits. Interleaved bursts of eight beats start at an odd offset, where XOR and addition give different sequences. A full-page burst starts at 0xFD with the interleave bit set. It shows the roll-over from 0xFF to 0x00, shows that the ordering bit is ignored, and shows that last_o stays low. Stops, restarts, a combined start and stop, and input changes during a burst test the priority and sampling rules.

// File: rtl/sdcol_pkg.sv
package sdcol_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIXED,
        ST_PAGE
    } col_state_e;

    localparam int LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] LEN_CODE_PAGE = 3'b111;
endpackage

// File: rtl/sdcol_mask.sv
// Decodes the burst length code into a mask of the column bits that move.
module sdcol_mask
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  page_o
);
    assign page_o = (code_i == LEN_CODE_PAGE);

    // A fixed code c (0..3) frees the low c bits; full page frees them all.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign mask_o[i] = page_o
                         | (!code_i[2] && (32'(code_i[1:0]) > i));
    end
endmodule

// File: rtl/sdcol_seq.sv
// Burst state machine: captures the burst settings and counts beats.
module sdcol_seq
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    input  logic             ilv_i,
    output col_state_e       state_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             vld_o,
    output logic             last_o
);
    col_state_e       state_q, state_d;
    logic [COL_W-1:0] beat_q, base_q, mask_q;
    logic             ilv_q;
    logic             at_end;

    assign at_end = (beat_q == mask_q);

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = page_i ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: if (stop_i || at_end) state_d = ST_IDLE;
                ST_PAGE:  if (stop_i) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                beat_q <= '0;
                base_q <= col_i;
                mask_q <= mask_i;
                ilv_q  <= ilv_i & ~page_i;
            end else if (state_q != ST_IDLE) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        vld_o  = 1'b0;
        last_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FIXED: begin vld_o = 1'b1; last_o = at_end; end
            ST_PAGE:  vld_o = 1'b1;
            default:  ;
        endcase
    end

    assign state_o = state_q;
    assign beat_o  = beat_q;
    assign base_o  = base_q;
    assign mask_o  = mask_q;
    assign ilv_o   = ilv_q;

    a_r2_start_beat0: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (vld_o && beat_q == '0 && base_q == $past(col_i)));
    a_r7_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last_o);
    a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !vld_o);
    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !vld_o);
    a_r10_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stop_i) |=> vld_o);
endmodule

// File: rtl/sdcol_addr.sv
// Forms the column of the current beat from the start column and beat count.
module sdcol_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    // The low bits of the full sum equal the wrapped sum of the low bits.
    assign sum = base_i + beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = !mask_i[i] ? base_i[i]
                        : (ilv_i ? (base_i[i] ^ beat_i[i]) : sum[i]);
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] blen_i,
    input  logic                  ilv_i,
    input  logic                  stop_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  beat_vld_o,
    output logic                  last_o
);
    logic [COL_W-1:0] new_mask, mask_q, beat_q, base_q;
    logic             new_page, ilv_q;
    col_state_e       state;

    sdcol_mask #(.COL_W(COL_W)) u_mask (
        .code_i (blen_i),
        .mask_o (new_mask),
        .page_o (new_page)
    );

    sdcol_seq #(.COL_W(COL_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop_i),
        .col_i   (start_col_i),
        .mask_i  (new_mask),
        .page_i  (new_page),
        .ilv_i   (ilv_i),
        .state_o (state),
        .beat_o  (beat_q),
        .base_o  (base_q),
        .mask_o  (mask_q),
        .ilv_o   (ilv_q),
        .vld_o   (beat_vld_o),
        .last_o  (last_o)
    );

    sdcol_addr #(.COL_W(COL_W)) u_addr (
        .base_i (base_q),
        .beat_i (beat_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (col_o)
    );

    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAGE && !start_i && !stop_i)
            |=> (col_o == $past(col_o) + 1'b1));
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !last_o && !start_i && !stop_i)
            |=> ((col_o & ~mask_q) == $past(col_o & ~mask_q)));
endmodule

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o, last_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
    );

    function automatic int exp_len(input logic [2:0] code);
        if (code == 3'b111) return 256;
        if (!code[2]) return 1 << code[1:0];
        return 1;
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic il, input int n);
        logic [7:0] m, nn;
        m  = 8'(exp_len(code) - 1);
        nn = 8'(n);
        if (code == 3'b111 || !il) return (s & ~m) | ((s + nn) & m);
        return (s & ~m) | ((s ^ nn) & m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic beat_chk(input logic [7:0] ec, input logic el, input string req);
        chk(beat_vld_o === 1'b1, req, int'(beat_vld_o), 1);
        chk(col_o === ec, req, int'(col_o), int'(ec));
        chk(last_o === el, req, int'(last_o), int'(el));
    endtask

    task automatic set_start(input logic [7:0] c, input logic [2:0] code, input logic il);
        start_i = 1'b1; start_col_i = c; blen_i = code; ilv_i = il;
    endtask

    // Whole fixed burst, then the idle cycle after it (R2, R3, R4, R5, R7).
    task automatic run_fixed(input logic [7:0] c, input logic [2:0] code,
                             input logic il, input string req);
        int len;
        len = exp_len(code);
        @(negedge clk); set_start(c, code, il);
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            if (n == 0) start_i = 1'b0;
            beat_chk(exp_col(c, code, il, n), n == len - 1, req);
        end
        @(negedge clk);
        chk(beat_vld_o === 1'b0, {req, " R7 idle after last"}, int'(beat_vld_o), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(beat_vld_o === 1'b0, "R1 vld in reset", int'(beat_vld_o), 0);
        chk(last_o === 1'b0, "R1 last in reset", int'(last_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(beat_vld_o === 1'b0, "R1 vld after reset", int'(beat_vld_o), 0);
    endtask

    task automatic t_page;
        @(negedge clk); set_start(8'hFD, 3'b111, 1'b1);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (n == 0) start_i = 1'b0;
            beat_chk(8'(8'hFD + n), 1'b0, "R6 full page wrap");
        end
        repeat (300) @(negedge clk);
        chk(beat_vld_o === 1'b1, "R6 page still running", int'(beat_vld_o), 1);
        chk(last_o === 1'b0, "R7 no last in page", int'(last_o), 0);
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(beat_vld_o === 1'b0, "R8 stop page", int'(beat_vld_o), 0);
    endtask

    task automatic t_stop;
        @(negedge clk); set_start(8'h40, 3'b011, 1'b0);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            if (n == 0) start_i = 1'b0;
            beat_chk(exp_col(8'h40, 3'b011, 1'b0, n), 1'b0, "R8 before stop");
        end
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(beat_vld_o === 1'b0, "R8 stop fixed", int'(beat_vld_o), 0);
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(beat_vld_o === 1'b0, "R8 stop idle", int'(beat_vld_o), 0);
        chk(last_o === 1'b0, "R8 stop idle last", int'(last_o), 0);
    endtask

    task automatic t_restart;
        @(negedge clk); set_start(8'h10, 3'b011, 1'b0);
        @(negedge clk); start_i = 1'b0;
        beat_chk(8'h10, 1'b0, "R9 first burst b0");
        @(negedge clk);
        beat_chk(8'h11, 1'b0, "R9 first burst b1");
        set_start(8'h82, 3'b010, 1'b1);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            if (n == 0) start_i = 1'b0;
            beat_chk(exp_col(8'h82, 3'b010, 1'b1, n), n == 3, "R9 restart");
        end
        @(negedge clk);
        chk(beat_vld_o === 1'b0, "R9 restart end", int'(beat_vld_o), 0);
    endtask

    task automatic t_start_stop;
        @(negedge clk); set_start(8'h20, 3'b011, 1'b0);
        @(negedge clk); start_i = 1'b0;
        set_start(8'hA5, 3'b001, 1'b0); stop_i = 1'b1;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
        beat_chk(8'hA5, 1'b0, "R10 start wins b0");
        @(negedge clk);
        beat_chk(8'hA4, 1'b1, "R10 start wins b1");
        @(negedge clk);
    endtask

    task automatic t_sample;
        @(negedge clk); set_start(8'h35, 3'b011, 1'b1);
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            if (n == 0) begin
                start_i = 1'b0; start_col_i = 8'hFF; blen_i = 3'b000; ilv_i = 1'b0;
            end
            beat_chk(exp_col(8'h35, 3'b011, 1'b1, n), n == 7, "R11 inputs held");
        end
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        run_fixed(8'h3E, 3'b010, 1'b0, "R4 seq BL4");
        run_fixed(8'h95, 3'b011, 1'b0, "R4 seq BL8");
        run_fixed(8'h01, 3'b001, 1'b0, "R3 seq BL2");
        run_fixed(8'h77, 3'b000, 1'b1, "R3 BL1");
        run_fixed(8'h35, 3'b011, 1'b1, "R5 ilv BL8");
        run_fixed(8'hC6, 3'b010, 1'b1, "R5 ilv BL4");
        run_fixed(8'h5A, 3'b101, 1'b0, "R3 reserved code");
        t_page();
        t_stop();
        t_restart();
        t_start_stop();
        t_sample();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule